// File: doc/BRIEF.md
# Multi-Mode Timer Channel Counter

This block is one 16-bit timer channel. It holds a counter, a data register that serves as reload value or capture target, and a channel-enable flag. A 3-bit mode input selects one of five behaviours: periodic down-counting, counting timer-input edges, measuring the interval between edges, single-shot down-counting started by an input edge, and single-shot measurement of a pulse width. The count clock comes in as a one-cycle enable pulse from an external prescaler. Software-style strobes start and stop the channel.

The modes differ mainly in how a start takes effect. Some modes load the counter only on the first count-clock pulse after start. The event mode loads it as soon as start is written. Some modes load the data register and count down, while others load zero and count up. The two single-shot modes arm into a waiting state and do nothing until an edge arrives on the timer input.

The timer input passes through a two-flop synchronizer and an edge register before any mode sees it. `edge_sel_i` picks the polarity that counts as the trigger edge.

Top module: `mm_timer_chan`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count_o` and `data_o` are 0 and `enabled_o`, `busy_o` and `irq_o` are low.
- R2: A cycle with `start_i` high (and `stop_i` low) sets `enabled_o`. A cycle with `stop_i` high clears `enabled_o` and `busy_o` and freezes `count_o`; later `tick_i` pulses leave it unchanged. `busy_o` is high only while the channel is enabled and is waiting either for a trigger edge or for its first-tick load.
- R3: Interval mode (`mode_i`=0; codes 5 to 7 behave the same). After start, `count_o` does not change until the first `tick_i` pulse. That pulse copies the data register into the counter and clears `busy_o`. Each later pulse decrements the counter by one.
- R4: In interval mode and in event mode, a count step taken while the counter is 0 raises `irq_o` for exactly one cycle and reloads the counter from the data register.
- R5: Event mode (`mode_i`=1). A start loads the data register into the counter in the same cycle, with no tick needed. After that, `tick_i` pulses with no input edge leave the counter unchanged.
- R6: In event mode, each detected trigger edge on `tin_i` makes the next `tick_i` pulse decrement the counter by exactly one.
- R7: Capture mode (`mode_i`=2). The first `tick_i` after start loads 0. Each later pulse increments the counter, wrapping from all-ones to 0.
- R8: In capture mode, a trigger edge copies the counter into the data register and pulses `irq_o` in the same cycle. The next `tick_i` restarts the count at 0.
- R9: One-count mode (`mode_i`=3). A start while stopped raises `busy_o`, and ticks leave the counter unchanged. After a trigger edge, the first tick loads the data register and later ticks decrement. A step at 0 pulses `irq_o`, holds 0 and returns the channel to waiting with `busy_o` high.
- R10: Capture-and-one-count mode (`mode_i`=4). A start while stopped enters waiting. After a trigger edge, the first tick loads 0 and later ticks increment. An edge of the opposite polarity copies the counter into the data register, pulses `irq_o` and returns the channel to waiting.
- R11: `edge_sel_i`=0 makes rising edges of `tin_i` the trigger and `edge_sel_i`=1 makes falling edges the trigger; a transition of the other polarity is not a trigger. A `tin_i` change made before clock edge N takes effect at clock edge N+2.
- R12: `data_we_i` writes `data_wdata_i` into the data register (seen on `data_o` next cycle), except in a cycle where a capture writes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe, wins over start |
| tick_i | input | 1 | Count-clock enable pulse |
| mode_i | input | 3 | Mode code |
| edge_sel_i | input | 1 | Trigger polarity: 0 rising, 1 falling |
| tin_i | input | 1 | Asynchronous timer input |
| data_we_i | input | 1 | Data register write enable |
| data_wdata_i | input | WIDTH | Data register write value |
| count_o | output | WIDTH | Counter value |
| data_o | output | WIDTH | Data register value |
| enabled_o | output | 1 | Channel enabled |
| busy_o | output | 1 | Armed, waiting for trigger or first-tick load |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check on every cycle that a start enables the channel and a stop disables it, and that counting stays frozen after a stop. They also check that waiting flags never outlive the enable and that an event-mode start loads the counter in one step. Further cycle-by-cycle checks cover a zero-count interrupt reloading from the data register and a capture interrupt carrying the previous count into the data register. Only the bench scenarios can show the mode sequences as a whole. These cover the load on the first tick, long up-count wrap runs, one decrement per input edge, and the ignored opposite polarity. They also cover re-arming after a single shot and the timing from a pin change to its effect.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    typedef enum logic [2:0] {
        MODE_INTERVAL = 3'd0,
        MODE_EVENT    = 3'd1,
        MODE_CAPTURE  = 3'd2,
        MODE_ONESHOT  = 3'd3,
        MODE_CAPONE   = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD_DATA,
        ACT_LOAD_ZERO,
        ACT_DEC,
        ACT_INC,
        ACT_CAPTURE
    } act_e;

    typedef struct packed {
        act_e act;
        logic irq;
    } cmd_t;

    localparam cmd_t CMD_IDLE = '{act: ACT_HOLD, irq: 1'b0};

    function automatic logic is_single_shot(input mode_e m);
        return (m == MODE_ONESHOT) || (m == MODE_CAPONE);
    endfunction

    function automatic cmd_t down_step(input logic at_zero);
        cmd_t c;
        c.act = at_zero ? ACT_LOAD_DATA : ACT_DEC;
        c.irq = at_zero;
        return c;
    endfunction

endpackage

// File: rtl/mtc_edge_sync.sv
module mtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LAST-1:0], pin_i};
    end

    assign rise_o =  chain_q[LAST-1] & ~chain_q[LAST];
    assign fall_o = ~chain_q[LAST-1] &  chain_q[LAST];

endmodule

// File: rtl/mtc_ctrl.sv
module mtc_ctrl
    import mtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  stop_i,
    input  logic  tick_i,
    input  logic [2:0] mode_i,
    input  logic  edge_sel_i,
    input  logic  rise_i,
    input  logic  fall_i,
    input  logic  cnt_zero_i,
    output cmd_t  cmd_o,
    output logic  enabled_o,
    output logic  busy_o
);
    mode_e mode;
    logic  trig_edge, end_edge;
    logic  en_q, lp_q, wt_q, ep_q;
    logic  en_n, lp_n, wt_n, ep_n;
    cmd_t  cmd;

    assign mode      = mode_e'(mode_i);
    assign trig_edge = edge_sel_i ? fall_i : rise_i;
    assign end_edge  = edge_sel_i ? rise_i : fall_i;

    always_comb begin
        en_n = en_q;
        lp_n = lp_q;
        wt_n = wt_q;
        ep_n = ep_q;
        cmd  = CMD_IDLE;
        if (stop_i) begin
            en_n = 1'b0;
            lp_n = 1'b0;
            wt_n = 1'b0;
            ep_n = 1'b0;
        end else if (start_i && !(is_single_shot(mode) && en_q)) begin
            en_n = 1'b1;
            ep_n = 1'b0;
            case (mode)
                MODE_EVENT: begin
                    lp_n    = 1'b0;
                    wt_n    = 1'b0;
                    cmd.act = ACT_LOAD_DATA;
                end
                MODE_ONESHOT, MODE_CAPONE: begin
                    lp_n = 1'b0;
                    wt_n = 1'b1;
                end
                default: begin
                    lp_n = 1'b1;
                    wt_n = 1'b0;
                end
            endcase
        end else if (en_q) begin
            case (mode)
                MODE_EVENT: begin
                    if (tick_i && ep_q) begin
                        ep_n = 1'b0;
                        cmd  = down_step(cnt_zero_i);
                    end
                    if (trig_edge) ep_n = 1'b1;
                end
                MODE_CAPTURE: begin
                    if (trig_edge) begin
                        cmd  = '{act: ACT_CAPTURE, irq: 1'b1};
                        lp_n = 1'b1;
                    end else if (tick_i) begin
                        cmd.act = lp_q ? ACT_LOAD_ZERO : ACT_INC;
                        lp_n    = 1'b0;
                    end
                end
                MODE_ONESHOT: begin
                    if (wt_q) begin
                        if (trig_edge) begin
                            wt_n = 1'b0;
                            lp_n = 1'b1;
                        end
                    end else if (tick_i) begin
                        if (lp_q) begin
                            cmd.act = ACT_LOAD_DATA;
                            lp_n    = 1'b0;
                        end else if (cnt_zero_i) begin
                            cmd.irq = 1'b1;
                            wt_n    = 1'b1;
                        end else begin
                            cmd.act = ACT_DEC;
                        end
                    end
                end
                MODE_CAPONE: begin
                    if (wt_q) begin
                        if (trig_edge) begin
                            wt_n = 1'b0;
                            lp_n = 1'b1;
                        end
                    end else if (end_edge) begin
                        cmd  = '{act: ACT_CAPTURE, irq: 1'b1};
                        wt_n = 1'b1;
                        lp_n = 1'b0;
                    end else if (tick_i) begin
                        cmd.act = lp_q ? ACT_LOAD_ZERO : ACT_INC;
                        lp_n    = 1'b0;
                    end
                end
                default: begin
                    if (tick_i) begin
                        if (lp_q) begin
                            cmd.act = ACT_LOAD_DATA;
                            lp_n    = 1'b0;
                        end else begin
                            cmd = down_step(cnt_zero_i);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            lp_q <= 1'b0;
            wt_q <= 1'b0;
            ep_q <= 1'b0;
        end else begin
            en_q <= en_n;
            lp_q <= lp_n;
            wt_q <= wt_n;
            ep_q <= ep_n;
        end
    end

    assign cmd_o     = cmd;
    assign enabled_o = en_q;
    assign busy_o    = wt_q | lp_q;

    assert_start_enables_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !stop_i) |=> en_q);

    assert_stop_clears_R2: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (!en_q && !wt_q && !lp_q && !ep_q));

    assert_busy_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        (wt_q || lp_q) |-> en_q);

    assert_waiting_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (wt_q && is_single_shot(mode)) |-> (cmd.act == ACT_HOLD && !cmd.irq));

endmodule

// File: rtl/mtc_datapath.sv
module mtc_datapath
    import mtc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd_i,
    input  logic             we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic [WIDTH-1:0] data_o,
    output logic             zero_o,
    output logic             irq_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q, data_q;
    logic             irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= cmd_i.irq;
            case (cmd_i.act)
                ACT_LOAD_DATA: cnt_q <= data_q;
                ACT_LOAD_ZERO: cnt_q <= '0;
                ACT_DEC:       cnt_q <= cnt_q - ONE;
                ACT_INC:       cnt_q <= cnt_q + ONE;
                default:       cnt_q <= cnt_q;
            endcase
            if (cmd_i.act == ACT_CAPTURE) data_q <= cnt_q;
            else if (we_i)                data_q <= wdata_i;
        end
    end

    assign cnt_o  = cnt_q;
    assign data_o = data_q;
    assign zero_o = (cnt_q == '0);
    assign irq_o  = irq_q;

endmodule

// File: rtl/mm_timer_chan.sv
module mm_timer_chan
    import mtc_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic [2:0]       mode_i,
    input  logic             edge_sel_i,
    input  logic             tin_i,
    input  logic             data_we_i,
    input  logic [WIDTH-1:0] data_wdata_i,
    output logic [WIDTH-1:0] count_o,
    output logic [WIDTH-1:0] data_o,
    output logic             enabled_o,
    output logic             busy_o,
    output logic             irq_o
);
    logic rise, fall, cnt_zero;
    cmd_t cmd;

    mtc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (tin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    mtc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .tick_i     (tick_i),
        .mode_i     (mode_i),
        .edge_sel_i (edge_sel_i),
        .rise_i     (rise),
        .fall_i     (fall),
        .cnt_zero_i (cnt_zero),
        .cmd_o      (cmd),
        .enabled_o  (enabled_o),
        .busy_o     (busy_o)
    );

    mtc_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .we_i    (data_we_i),
        .wdata_i (data_wdata_i),
        .cnt_o   (count_o),
        .data_o  (data_o),
        .zero_o  (cnt_zero),
        .irq_o   (irq_o)
    );

    assert_stop_freezes_R2: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (count_o == $past(count_o)));

    assert_event_start_load_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && !stop_i && mode_i == MODE_EVENT) |=> (count_o == $past(data_o)));

    assert_zero_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_o && $past(mode_i) == MODE_INTERVAL)
            |-> ($past(count_o) == '0 && count_o == $past(data_o)));

    assert_capture_copy_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_o && $past(mode_i) == MODE_CAPTURE) |-> (data_o == $past(count_o)));

endmodule

// File: tb/mm_timer_chan_test.sv
`timescale 1ns/1ps
module mm_timer_chan_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0, stop = 1'b0, tick = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         esel = 1'b0, tin = 1'b0, we = 1'b0;
    logic [W-1:0] wd = '0;
    logic [W-1:0] count, data;
    logic         enabled, busy, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mm_timer_chan #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .tick_i(tick),
        .mode_i(mode), .edge_sel_i(esel), .tin_i(tin), .data_we_i(we),
        .data_wdata_i(wd), .count_o(count), .data_o(data),
        .enabled_o(enabled), .busy_o(busy), .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic st, input logic sp, input logic tk);
        start = st; stop = sp; tick = tk;
        @(negedge clk);
        start = 1'b0; stop = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input logic [W-1:0] v);
        we = 1'b1; wd = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic pin(input logic v);
        tin = v;
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int hold;
        repeat (3) @(negedge clk);
        chk("R1 count in reset", count, 0);
        chk("R1 enabled in reset", enabled, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 count", count, 0);
        chk("R1 data", data, 0);
        chk("R1 flags", {enabled, busy, irq}, 0);

        wr(8'd5);
        chk("R12 data write", data, 5);

        // interval sweep over small reload values
        for (int d = 0; d < 8; d++) begin
            cyc(1'b0, 1'b1, 1'b0);
            wr(W'(d));
            hold = count;
            cyc(1'b1, 1'b0, 1'b0);
            chk("R2 start enables", enabled, 1);
            chk("R3 busy before load", busy, 1);
            repeat (2) cyc(1'b0, 1'b0, 1'b0);
            chk("R3 no change before tick", count, hold);
            cyc(1'b0, 1'b0, 1'b1);
            chk("R3 first tick loads", count, d);
            chk("R3 busy cleared", busy, 0);
            for (int k = 1; k <= d; k++) begin
                cyc(1'b0, 1'b0, 1'b1);
                chk("R3 decrement", count, d - k);
                chk("R4 no irq above zero", irq, 0);
            end
            cyc(1'b0, 1'b0, 1'b1);
            chk("R4 irq at zero", irq, 1);
            chk("R4 reload", count, d);
            cyc(1'b0, 1'b0, 1'b0);
            chk("R4 irq one cycle", irq, 0);
        end

        // stop freezes
        cyc(1'b0, 1'b1, 1'b0);
        wr(8'd9);
        cyc(1'b1, 1'b0, 1'b0);
        repeat (3) cyc(1'b0, 1'b0, 1'b1);
        chk("R3 count 7", count, 7);
        cyc(1'b0, 1'b1, 1'b0);
        chk("R2 stop disables", enabled, 0);
        chk("R2 stop busy", busy, 0);
        repeat (3) cyc(1'b0, 1'b0, 1'b1);
        chk("R2 frozen", count, 7);

        // event mode
        mode = 3'd1;
        wr(8'd3);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R5 immediate load", count, 3);
        repeat (4) cyc(1'b0, 1'b0, 1'b1);
        chk("R5 ticks without edge", count, 3);
        for (int i = 1; i <= 3; i++) begin
            pin(1'b1);
            chk("R6 no step before tick", count, 4 - i);
            cyc(1'b0, 1'b0, 1'b1);
            chk("R6 one step per edge", count, 3 - i);
            cyc(1'b0, 1'b0, 1'b1);
            chk("R6 second tick no step", count, 3 - i);
            pin(1'b0);
            cyc(1'b0, 1'b0, 1'b1);
            chk("R11 falling ignored", count, 3 - i);
        end
        pin(1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R4 event irq", irq, 1);
        chk("R4 event reload", count, 3);
        pin(1'b0);

        // capture mode
        cyc(1'b0, 1'b1, 1'b0);
        mode = 3'd2;
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R7 first tick zero", count, 0);
        for (int k = 1; k <= 300; k++) begin
            cyc(1'b0, 1'b0, 1'b1);
            chk("R7 increment wrap", count, k % 256);
        end
        tin = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R11 not yet seen", irq, 0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R8 capture irq", irq, 1);
        chk("R8 captured value", data, 44);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R8 restart zero", count, 0);
        chk("R8 irq one cycle", irq, 0);
        esel = 1'b1;
        repeat (6) cyc(1'b0, 1'b0, 1'b1);
        chk("R7 count 6", count, 6);
        pin(1'b0);
        chk("R11 falling capture irq", irq, 1);
        chk("R11 falling capture value", data, 6);
        esel = 1'b0;

        // one-count mode
        cyc(1'b0, 1'b1, 1'b0);
        mode = 3'd3;
        wr(8'd2);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R9 waiting busy", busy, 1);
        chk("R9 enabled", enabled, 1);
        repeat (3) cyc(1'b0, 1'b0, 1'b1);
        chk("R9 no count while waiting", count, 6);
        pin(1'b1);
        chk("R9 busy until load", busy, 1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R9 load data", count, 2);
        chk("R9 running", busy, 0);
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R9 down to zero", count, 0);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R9 irq", irq, 1);
        chk("R9 rearmed", busy, 1);
        repeat (2) cyc(1'b0, 1'b0, 1'b1);
        chk("R9 holds zero", count, 0);
        chk("R9 single irq", irq, 0);
        pin(1'b0);
        pin(1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R9 retrigger load", count, 2);

        // capture and one-count mode
        cyc(1'b0, 1'b1, 1'b0);
        mode = 3'd4;
        pin(1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R10 waiting", busy, 1);
        repeat (2) cyc(1'b0, 1'b0, 1'b1);
        chk("R10 no count while waiting", count, 2);
        pin(1'b1);
        chk("R10 busy until load", busy, 1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R10 load zero", count, 0);
        repeat (4) cyc(1'b0, 1'b0, 1'b1);
        chk("R10 increment", count, 4);
        pin(1'b0);
        chk("R10 end irq", irq, 1);
        chk("R10 captured width", data, 4);
        chk("R10 back to waiting", busy, 1);
        repeat (2) cyc(1'b0, 1'b0, 1'b1);
        chk("R10 held while waiting", count, 4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule